// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This block is the combinational rotate/shift and single-bit-test stage of an 8-bit processor datapath. It takes an operand byte, the current flag byte and an operation code. It returns the new byte and the new flag byte in the same cycle. Instruction decode and any memory write-back sit outside the block: the surrounding core supplies the operation code and stores the result.

Eight shift kinds are supported: two circular rotates, two rotates through carry, two left shifts (one fills with zero, the other fills with one) and two right shifts (one keeps the sign, the other fills with zero). A bit-test operation checks one selected bit. It has a plain form and an indexed form. The indexed form takes two undocumented flag bits from the high byte of the effective address instead of the operand.

Top module: `shift_bit_unit`

## Requirements
- R1: opSel 0 rotates left circularly (old bit 7 goes to bit 0 and to carry). opSel 1 rotates right circularly (old bit 0 goes to bit 7 and to carry).
- R2: opSel 2 rotates left through carry (incoming carry to bit 0, old bit 7 to carry). opSel 3 rotates right through carry (incoming carry to bit 7, old bit 0 to carry).
- R3: opSel 4 shifts left and fills bit 0 with 0. opSel 6 shifts left and fills bit 0 with 1. Both put old bit 7 into carry.
- R4: opSel 5 shifts right and keeps bit 7. opSel 7 shifts right and fills bit 7 with 0. Both put old bit 0 into carry.
- R5: The flag byte uses these positions: bit 7 S, bit 6 Z, bit 5 copy, bit 4 H, bit 3 copy, bit 2 P/V, bit 1 N, bit 0 C. For opSel 0 to 7, H and N are 0. S, Z, both copy bits and even parity (P/V=1 when the result has an even number of ones) all come from the result.
- R6: opSel 8 is the bit test. It tests operand bit bitIdx and passes the operand unchanged to result. It keeps the incoming C, sets H, and clears N. Z and P/V are both 1 exactly when the tested bit is 0.
- R7: In the bit test, S is 1 only when bitIdx is 7 and operand bit 7 is 1.
- R8: In the bit test, flag bits 5 and 3 are copied from the operand when idxMode is 0 and from addrHi when idxMode is 1. For opSel 0 to 7, idxMode and addrHi have no effect.
- R9: opSel 9 to 15 are inert: result equals the operand and flagsOut equals flagsIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| bitIdx | input | 3 | Index of the bit to test |
| idxMode | input | 1 | Selects the indexed bit-test form |
| operand | input | 8 | Byte to operate on |
| addrHi | input | 8 | High byte of the effective address |
| flagsIn | input | 8 | Current flag byte |
| result | output | 8 | Resulting byte |
| flagsOut | output | 8 | New flag byte |

## Verification
The bit-test S rule and the Z/P/V rule both apply when index 7 is tested. The bench drives index 7 with bit 7 set and with bit 7 clear, and checks that S and Z never both end up set. It also checks that Z and P/V always match. A second overlap comes from raising idxMode with a nonzero addrHi during every shift code. The bench then checks that the copy bits still follow the result and not addrHi.

// File: rtl/shift_bit_pkg.sv
package shift_bit_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int OP_W   = 4;

  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_X3 = 3;
  localparam int FL_H  = 4;
  localparam int FL_X5 = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ROT_LC  = 4'd0,
    OP_ROT_RC  = 4'd1,
    OP_ROT_LT  = 4'd2,
    OP_ROT_RT  = 4'd3,
    OP_SHL_Z   = 4'd4,
    OP_SHR_A   = 4'd5,
    OP_SHL_O   = 4'd6,
    OP_SHR_L   = 4'd7,
    OP_BITTEST = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    FILL_ZERO, FILL_ONE, FILL_CARRY, FILL_WRAP, FILL_SIGN
  } fill_e;

  typedef struct packed {
    logic  doShift;
    logic  doBit;
    logic  goLeft;
    fill_e fillKind;
  } ctrl_t;
endpackage

// File: rtl/shift_bit_ctrl.sv
module shift_bit_ctrl
  import shift_bit_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{doShift: 1'b0, doBit: 1'b0, goLeft: 1'b0, fillKind: FILL_ZERO};
    case (opSel)
      OP_ROT_LC:  ctrl = '{1'b1, 1'b0, 1'b1, FILL_WRAP};
      OP_ROT_RC:  ctrl = '{1'b1, 1'b0, 1'b0, FILL_WRAP};
      OP_ROT_LT:  ctrl = '{1'b1, 1'b0, 1'b1, FILL_CARRY};
      OP_ROT_RT:  ctrl = '{1'b1, 1'b0, 1'b0, FILL_CARRY};
      OP_SHL_Z:   ctrl = '{1'b1, 1'b0, 1'b1, FILL_ZERO};
      OP_SHR_A:   ctrl = '{1'b1, 1'b0, 1'b0, FILL_SIGN};
      OP_SHL_O:   ctrl = '{1'b1, 1'b0, 1'b1, FILL_ONE};
      OP_SHR_L:   ctrl = '{1'b1, 1'b0, 1'b0, FILL_ZERO};
      OP_BITTEST: ctrl = '{1'b0, 1'b1, 1'b0, FILL_ZERO};
      default:    ctrl = '{1'b0, 1'b0, 1'b0, FILL_ZERO};
    endcase
  end
endmodule

// File: rtl/shift_bit_path.sv
module shift_bit_path
  import shift_bit_pkg::*;
(
  input  ctrl_t              ctrl,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic               idxMode,
  input  logic [DATA_W-1:0]  operand,
  input  logic [DATA_W-1:0]  addrHi,
  input  logic [DATA_W-1:0]  flagsIn,
  output logic [DATA_W-1:0]  result,
  output logic [DATA_W-1:0]  flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic              fillBit;
  logic              outCarry;
  logic [MSB:0]      shifted;
  logic [MSB:0]      shiftFlags;
  logic [MSB:0]      bitFlags;
  logic [MSB:0]      copySrc;
  logic              testedBit;

  // Bit inserted at the vacated end
  always_comb begin
    case (ctrl.fillKind)
      FILL_ONE:   fillBit = 1'b1;
      FILL_CARRY: fillBit = flagsIn[FL_C];
      FILL_WRAP:  fillBit = ctrl.goLeft ? operand[MSB] : operand[0];
      FILL_SIGN:  fillBit = operand[MSB];
      default:    fillBit = 1'b0;
    endcase
  end

  always_comb begin
    if (ctrl.goLeft) begin
      shifted  = {operand[MSB-1:0], fillBit};
      outCarry = operand[MSB];
    end else begin
      shifted  = {fillBit, operand[MSB:1]};
      outCarry = operand[0];
    end
  end

  always_comb begin
    shiftFlags        = '0;
    shiftFlags[FL_S]  = shifted[MSB];
    shiftFlags[FL_Z]  = (shifted == '0);
    shiftFlags[FL_X5] = shifted[5];
    shiftFlags[FL_X3] = shifted[3];
    shiftFlags[FL_PV] = ~^shifted;
    shiftFlags[FL_C]  = outCarry;
  end

  assign testedBit = operand[bitIdx];
  assign copySrc   = idxMode ? addrHi : operand;

  always_comb begin
    bitFlags        = '0;
    bitFlags[FL_S]  = (bitIdx == IDX_W'(MSB)) && testedBit;
    bitFlags[FL_Z]  = ~testedBit;
    bitFlags[FL_X5] = copySrc[5];
    bitFlags[FL_H]  = 1'b1;
    bitFlags[FL_X3] = copySrc[3];
    bitFlags[FL_PV] = ~testedBit;
    bitFlags[FL_C]  = flagsIn[FL_C];
  end

  always_comb begin
    if (ctrl.doShift) begin
      result   = shifted;
      flagsOut = shiftFlags;
    end else if (ctrl.doBit) begin
      result   = operand;
      flagsOut = bitFlags;
    end else begin
      result   = operand;
      flagsOut = flagsIn;
    end
  end
endmodule

// File: rtl/shift_bit_unit.sv
module shift_bit_unit
  import shift_bit_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic [2:0] bitIdx,
  input  logic       idxMode,
  input  logic [7:0] operand,
  input  logic [7:0] addrHi,
  input  logic [7:0] flagsIn,
  output logic [7:0] result,
  output logic [7:0] flagsOut
);
  ctrl_t ctrl;

  shift_bit_ctrl uCtrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  shift_bit_path uPath (
    .ctrl     (ctrl),
    .bitIdx   (bitIdx),
    .idxMode  (idxMode),
    .operand  (operand),
    .addrHi   (addrHi),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );
endmodule

// File: rtl/shift_bit_unit_chk.sv
module shift_bit_unit_chk (
  input logic [3:0] opSel,
  input logic [2:0] bitIdx,
  input logic       idxMode,
  input logic [7:0] operand,
  input logic [7:0] addrHi,
  input logic [7:0] flagsIn,
  input logic [7:0] result,
  input logic [7:0] flagsOut
);
  logic isShift, isBit, isIdle;
  assign isShift = (opSel < 4'd8);
  assign isBit   = (opSel == 4'd8);
  assign isIdle  = (opSel > 4'd8);

  always_comb begin
    if (isShift) begin
      AST_SHIFT_HN_CLEAR: assert (flagsOut[4] == 1'b0 && flagsOut[1] == 1'b0); // R5
      AST_SHIFT_ZERO_FLAG: assert (flagsOut[6] == (result == 8'h00)); // R5
      AST_SHIFT_SIGN_FLAG: assert (flagsOut[7] == result[7]); // R5
    end
    if (isBit) begin
      AST_BIT_KEEPS_BYTE: assert (result == operand && flagsOut[0] == flagsIn[0]); // R6
      AST_BIT_Z_EQ_PV: assert (flagsOut[6] == flagsOut[2] && flagsOut[4]); // R6
      AST_BIT_SIGN_RULE: assert (!flagsOut[7] || (bitIdx == 3'd7 && operand[7])); // R7
      AST_BIT_COPY_SRC: assert (flagsOut[5] == (idxMode ? addrHi[5] : operand[5])); // R8
    end
    if (isIdle) begin
      AST_IDLE_PASS: assert (result == operand && flagsOut == flagsIn); // R9
    end
  end
endmodule

bind shift_bit_unit shift_bit_unit_chk uChk (.*);

// File: tb/shift_bit_unit_test.sv
`timescale 1ns/1ps
module shift_bit_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opSel = '0;
  logic [2:0] bitIdx = '0;
  logic       idxMode = 1'b0;
  logic [7:0] operand = '0;
  logic [7:0] addrHi = '0;
  logic [7:0] flagsIn = '0;
  logic [7:0] result;
  logic [7:0] flagsOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shift_bit_unit uut (
    .opSel(opSel), .bitIdx(bitIdx), .idxMode(idxMode), .operand(operand),
    .addrHi(addrHi), .flagsIn(flagsIn), .result(result), .flagsOut(flagsOut)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] op;
    logic [2:0] idx;
    logic       im;
    logic [7:0] opnd;
    logic [7:0] ahi;
    logic [7:0] fin;
    logic [7:0] expRes;
    logic [7:0] expFl;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1, 4'h0, 3'd0, 1'b0, 8'h81, 8'h00, 8'h00, 8'h03, 8'h05}, // R1
    '{4'd1, 4'h1, 3'd0, 1'b0, 8'h01, 8'h00, 8'h00, 8'h80, 8'h81}, // R1
    '{4'd2, 4'h2, 3'd0, 1'b0, 8'h80, 8'h00, 8'h01, 8'h01, 8'h01}, // R2
    '{4'd2, 4'h3, 3'd0, 1'b0, 8'h01, 8'h00, 8'h01, 8'h80, 8'h81}, // R2
    '{4'd3, 4'h4, 3'd0, 1'b0, 8'h80, 8'h00, 8'hFF, 8'h00, 8'h45}, // R3
    '{4'd3, 4'h6, 3'd0, 1'b0, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01}, // R3
    '{4'd4, 4'h5, 3'd0, 1'b0, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h85}, // R4
    '{4'd4, 4'h7, 3'd0, 1'b0, 8'h81, 8'h00, 8'h00, 8'h40, 8'h01}, // R4
    '{4'd5, 4'h0, 3'd0, 1'b1, 8'h14, 8'hFF, 8'h00, 8'h28, 8'h2C}, // R5 R8
    '{4'd7, 4'h8, 3'd7, 1'b0, 8'h80, 8'h00, 8'h01, 8'h80, 8'h91}, // R7
    '{4'd6, 4'h8, 3'd3, 1'b0, 8'hF7, 8'h00, 8'h00, 8'hF7, 8'h74}, // R6
    '{4'd7, 4'h8, 3'd7, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h54}, // R7
    '{4'd8, 4'h8, 3'd0, 1'b1, 8'h01, 8'h28, 8'hFE, 8'h01, 8'h38}, // R8
    '{4'd9, 4'hF, 3'd0, 1'b0, 8'h5A, 8'h00, 8'hC3, 8'h5A, 8'hC3}  // R9
  };

  task automatic check(input string tag, input logic [7:0] gotR, input logic [7:0] expR,
                       input logic [7:0] gotF, input logic [7:0] expF);
    checks++;
    if (gotR !== expR || gotF !== expF) begin
      errors++;
      $display("FAIL %s: result %h flags %h, expected result %h flags %h",
               tag, gotR, gotF, expR, expF);
    end
  endtask

  // Independent reference built from the requirement text, bit by bit
  function automatic logic [15:0] model(input logic [3:0] op, input logic [2:0] idx,
      input logic im, input logic [7:0] v, input logic [7:0] ah, input logic [7:0] f);
    logic [7:0] r;
    logic [7:0] fl;
    logic       c;
    int         ones;
    r = v; fl = f; c = 1'b0;
    case (op)
      4'd0: begin c = v[7]; r = (v << 1) | (v >> 7); end
      4'd1: begin c = v[0]; r = (v >> 1) | (v << 7); end
      4'd2: begin c = v[7]; r = (v << 1) | {7'b0, f[0]}; end
      4'd3: begin c = v[0]; r = (v >> 1) | {f[0], 7'b0}; end
      4'd4: begin c = v[7]; r = v << 1; end
      4'd5: begin c = v[0]; r = (v >> 1) | (v & 8'h80); end
      4'd6: begin c = v[7]; r = (v << 1) | 8'h01; end
      4'd7: begin c = v[0]; r = v >> 1; end
      default: ;
    endcase
    if (op < 4'd8) begin
      ones = 0;
      for (int k = 0; k < 8; k++) ones += r[k];
      fl = (r & 8'hA8) | ((r == 0) ? 8'h40 : 8'h00) |
           ((ones % 2 == 0) ? 8'h04 : 8'h00) | {7'b0, c};
    end else if (op == 4'd8) begin
      fl = 8'h10 | (f & 8'h01) | ((im ? ah : v) & 8'h28);
      if (((v >> idx) & 8'h01) == 0) fl = fl | 8'h44;
      else if (idx == 3'd7) fl = fl | 8'h80;
    end
    return {r, fl};
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: result %h flags %h, expected completion", result, flagsOut);
      finish_run();
    end
  end

  initial begin
    logic [15:0] exp;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle inputs after reset: op 0 on zero operand gives 0 with Z and P/V (R1 R5)
    check("R5 reset state", result, 8'h00, flagsOut, 8'h44);

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      opSel = VECS[i].op; bitIdx = VECS[i].idx; idxMode = VECS[i].im;
      operand = VECS[i].opnd; addrHi = VECS[i].ahi; flagsIn = VECS[i].fin;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            result, VECS[i].expRes, flagsOut, VECS[i].expFl);
    end

    // Sweep: all shift codes (R1 R2 R3 R4 R5), idxMode raised with addrHi set (R8)
    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 256; v++) begin
        for (int cin = 0; cin < 2; cin++) begin
          opSel = 4'(op); operand = 8'(v); flagsIn = cin ? 8'h01 : 8'hFE;
          idxMode = v[0]; addrHi = 8'h28; bitIdx = 3'(v);
          #1;
          exp = model(opSel, bitIdx, idxMode, operand, addrHi, flagsIn);
          check($sformatf("R5 shift op %0d v %h", op, v), result, exp[15:8], flagsOut, exp[7:0]);
        end
      end
    end

    // Bit test sweep, both forms (R6 R7 R8)
    for (int v = 0; v < 256; v++) begin
      for (int k = 0; k < 8; k++) begin
        for (int m = 0; m < 2; m++) begin
          opSel = 4'd8; operand = 8'(v); bitIdx = 3'(k); idxMode = m[0];
          addrHi = 8'(v * 7 + 13); flagsIn = 8'(v ^ 8'h5B);
          #1;
          exp = model(opSel, bitIdx, idxMode, operand, addrHi, flagsIn);
          check($sformatf("R6 R7 R8 bit %0d v %h", k, v), result, exp[15:8], flagsOut, exp[7:0]);
        end
      end
    end

    // Inert codes (R9)
    for (int op = 9; op < 16; op++) begin
      opSel = 4'(op); operand = 8'(op * 17); flagsIn = 8'(op * 29); idxMode = 1'b1;
      #1;
      check($sformatf("R9 inert op %0d", op), result, operand, flagsOut, flagsIn);
    end

    done = 1;
    finish_run();
  end
endmodule